// File: doc/BRIEF.md
# I2C Slave Register Access Engine

This block is an I2C target that gives an external bus master byte-wide read and write access to a small bank of nine 8-bit locations, numbered 0 to 8. The block runs on a fast system clock. It passes SCL and SDA through a two-flop synchronizer and finds their edges in the system clock domain. It recognises START, repeated START and STOP. It answers only to an identification byte that carries a fixed prefix followed by three strap bits. It never stretches the clock.

A transfer begins with an address byte, which loads a location pointer. A write then stores each following data byte at the pointer and advances the pointer. A read needs a pointer write first, then a repeated START and a read identification byte; the block then streams bytes from the pointer for as long as the master acknowledges. In both directions the pointer steps from 8 back to 0. The storage itself sits outside the block, behind a plain register port, and a busy input lets that storage refuse writes.

Top module: `i2cRegSlave`

## Requirements
- R1: After reset the block does not drive SDA (`sdaOe` = 0), issues no register write, and presents location 0 on `regAddr`.
- R2: An identification byte whose upper seven bits, sent MSB first, equal binary 1010 followed by `strapId[2]`, `strapId[1]` and `strapId[0]` is acknowledged. Any other value gets no acknowledge, and the block then ignores all bus traffic (no ACK, no register write) until the next START or STOP.
- R3: In a write transfer (START, identification byte with bit 0 = 0, address byte, data bytes, STOP) each byte is acknowledged. Each data byte appears on `regWdata` with a one-cycle `regWr` pulse at the location held by the pointer.
- R4: After each data byte stored by a write, the pointer advances by one, and it steps from location 8 to location 0.
- R5: After a pointer write, a repeated START and an identification byte with bit 0 = 1, the block sends the byte at the pointer MSB first. Each later byte the master acknowledges comes from the next location, stepping from 8 to 0.
- R6: When the master does not acknowledge a read byte, the block stops driving SDA and sends nothing more until a START arrives.
- R7: A data byte that completes while `regBusy` is high is not written and is not acknowledged.
- R8: While `initDone` is low, a START is ignored, so a following identification byte gets no acknowledge.
- R9: After STOP the block is idle. Bytes clocked without a new START get no acknowledge and cause no write.
- R10: The block changes `sdaOe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strapId | input | 3 | Strap bits compared with identification bits 3..1 |
| initDone | input | 1 | High once the power-up sequence is over |
| regBusy | input | 1 | Storage refuses writes while high |
| regRdata | input | 8 | Storage read data for `regAddr`, valid in the same cycle |
| regRd | output | 1 | One-cycle pulse when a read byte is fetched |
| regWr | output | 1 | One-cycle write pulse |
| regAddr | output | 4 | Location pointer |
| regWdata | output | 8 | Write data |

## Verification
A data byte written to the storage and the pointer step happen on the same system clock edge. The write must land at the old location, and only the next byte may use the new one. Bursts that cross location 8 provoke this, and read-back through the bus judges it. The bench also raises `regBusy` across a whole data byte, while the identification and address bytes are still acknowledged. It then checks that the busy refusal suppresses both the write and the pointer step.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVID, ST_DEVACK, ST_ADDR, ST_ADDRACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_SKIP
  } busState_e;

  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ptrLoad;
    logic ptrInc;
  } dpStrobe_t;
endpackage

// File: rtl/i2cRegSync.sv
module i2cRegSync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegPkg::*;
#(
  parameter int PTR_W     = 4,
  parameter int LAST_ADDR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] regRdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [PTR_W-1:0]  ptr
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(LAST_ADDR);

  logic [BYTE_W-1:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txReg  <= '1;
      ptr    <= '0;
    end else begin
      if (strobe.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (strobe.txLoad)       txReg <= regRdata;
      else if (strobe.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b1};
      if (strobe.ptrLoad)     ptr <= rxByte[PTR_W-1:0];
      else if (strobe.ptrInc) ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
    end
  end

  assign txMsb = txReg[BYTE_W-1];
endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter int                  PREFIX_W  = 4,
  parameter logic [PREFIX_W-1:0] ID_PREFIX = 4'b1010,
  localparam int                 STRAP_W   = ID_W - PREFIX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startCond,
  input  logic               stopCond,
  input  logic               sdaBit,
  input  logic               initDone,
  input  logic               regBusy,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic [STRAP_W-1:0] strapId,
  output dpStrobe_t          strobe,
  output logic               regWr,
  output logic               ackOut,
  output logic               txActive
);
  localparam logic [3:0] FULL_CNT = 4'(BYTE_W);

  busState_e  state, nxt;
  logic [3:0] bitCnt;
  logic       ackDrive, ackNxt, isRead, readNxt, mAck;
  logic       rxPhase, ackPhase, byteEnd, ackEnd, idMatch, startOk;

  assign rxPhase  = (state == ST_DEVID) || (state == ST_ADDR) || (state == ST_WDATA);
  assign ackPhase = (state == ST_DEVACK) || (state == ST_ADDRACK) ||
                    (state == ST_WACK) || (state == ST_RACK);
  assign byteEnd  = sclFall && (bitCnt == FULL_CNT);
  assign ackEnd   = sclFall && (bitCnt == 4'd1);
  assign idMatch  = (rxByte[BYTE_W-1:1] == {ID_PREFIX, strapId});
  assign startOk  = startCond && initDone;

  always_comb begin
    nxt     = state;
    strobe  = '0;
    regWr   = 1'b0;
    ackNxt  = ackDrive;
    readNxt = isRead;
    if (rxPhase && sclRise) strobe.rxShift = 1'b1;
    if (state == ST_RDATA && sclFall && bitCnt != 4'd0 && bitCnt != FULL_CNT)
      strobe.txShift = 1'b1;
    unique case (state)
      ST_DEVID: if (byteEnd) begin
        if (idMatch) begin
          nxt = ST_DEVACK; ackNxt = 1'b1; readNxt = rxByte[0];
        end else nxt = ST_SKIP;
      end
      ST_ADDR: if (byteEnd) begin
        strobe.ptrLoad = 1'b1; ackNxt = 1'b1; nxt = ST_ADDRACK;
      end
      ST_WDATA: if (byteEnd) begin
        nxt = ST_WACK;
        if (!regBusy) begin
          regWr = 1'b1; strobe.ptrInc = 1'b1; ackNxt = 1'b1;
        end else ackNxt = 1'b0;
      end
      ST_RDATA: if (byteEnd) begin
        nxt = ST_RACK; strobe.ptrInc = 1'b1; ackNxt = 1'b0;
      end
      ST_DEVACK: if (ackEnd) begin
        ackNxt = 1'b0;
        if (isRead) begin nxt = ST_RDATA; strobe.txLoad = 1'b1; end
        else nxt = ST_ADDR;
      end
      ST_ADDRACK: if (ackEnd) begin ackNxt = 1'b0; nxt = ST_WDATA; end
      ST_WACK: if (ackEnd) begin
        ackNxt = 1'b0; nxt = ackDrive ? ST_WDATA : ST_SKIP;
      end
      ST_RACK: if (ackEnd) begin
        if (mAck) begin nxt = ST_RDATA; strobe.txLoad = 1'b1; end
        else nxt = ST_SKIP;
      end
      default: ;
    endcase
    if (stopCond) begin
      nxt = ST_IDLE; ackNxt = 1'b0;
    end else if (startOk) begin
      nxt = ST_DEVID; ackNxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      isRead   <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state    <= nxt;
      ackDrive <= ackNxt;
      isRead   <= readNxt;
      if (nxt != state || startOk)           bitCnt <= '0;
      else if (sclRise && bitCnt != FULL_CNT) bitCnt <= bitCnt + 1'b1;
      if (state == ST_RACK && sclRise) mAck <= ~sdaBit;
    end
  end

  assign ackOut   = ackPhase && ackDrive;
  assign txActive = (state == ST_RDATA);
endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter int                  PTR_W       = 4,
  parameter int                  LAST_ADDR   = 8,
  parameter int                  PREFIX_W    = 4,
  parameter logic [PREFIX_W-1:0] ID_PREFIX   = 4'b1010,
  parameter int                  SYNC_STAGES = 2,
  localparam int                 STRAP_W     = ID_W - PREFIX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [STRAP_W-1:0] strapId,
  input  logic               initDone,
  input  logic               regBusy,
  input  logic [BYTE_W-1:0]  regRdata,
  output logic               regRd,
  output logic               regWr,
  output logic [PTR_W-1:0]   regAddr,
  output logic [BYTE_W-1:0]  regWdata
);
  logic      sclS, sdaS, sclD, sdaD;
  logic      sclRise, sclFall, startCond, stopCond;
  logic      ackOut, txActive, txMsb;
  dpStrobe_t strobe;

  i2cRegSync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout({sclS, sdaS})
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin sclD <= 1'b1; sdaD <= 1'b1; end
    else       begin sclD <= sclS; sdaD <= sdaS; end

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;

  i2cRegCtrl #(.PREFIX_W(PREFIX_W), .ID_PREFIX(ID_PREFIX)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaBit(sdaS),
    .initDone(initDone), .regBusy(regBusy), .rxByte(regWdata),
    .strapId(strapId), .strobe(strobe), .regWr(regWr),
    .ackOut(ackOut), .txActive(txActive)
  );

  i2cRegData #(.PTR_W(PTR_W), .LAST_ADDR(LAST_ADDR)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaS),
    .regRdata(regRdata), .rxByte(regWdata), .txMsb(txMsb), .ptr(regAddr)
  );

  assign regRd = strobe.txLoad;
  assign sdaOe = ackOut | (txActive & ~txMsb);
endmodule

// File: rtl/i2cRegSlaveChk.sv
module i2cRegSlaveChk #(
  parameter int PTR_W     = 4,
  parameter int LAST_ADDR = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaOe,
  input logic             regWr,
  input logic             regRd,
  input logic             regBusy,
  input logic [PTR_W-1:0] regAddr
);
  function automatic logic [PTR_W-1:0] stepOf(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(LAST_ADDR)) ? '0 : p + 1'b1;
  endfunction

  assert_wr_rd_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> (regAddr == stepOf($past(regAddr))));

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> !regBusy);

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind i2cRegSlave i2cRegSlaveChk #(.PTR_W(PTR_W), .LAST_ADDR(LAST_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .regWr(regWr),
  .regRd(regRd), .regBusy(regBusy), .regAddr(regAddr)
);

// File: tb/i2cRegSlave_tb.sv
module i2cRegSlave_tb_top;
  localparam int LASTA = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ID_WR = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] ID_RD = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] ID_BAD = {4'b1010, 3'b100, 1'b0};

  logic clk = 1'b0, rstN = 1'b0, initDone = 1'b0, regBusy = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, regRd, regWr, sdaLine;
  logic [3:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [7:0] regs [0:LASTA];
  logic [7:0] model [0:LASTA];
  int nChecks = 0, nFail = 0, r10Viol = 0, cycles = 0;
  logic prevOe = 1'b0;

  always #10 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  i2cRegSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapId(STRAP), .initDone(initDone), .regBusy(regBusy),
    .regRdata(regRdata), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata)
  );

  assign regRdata = (regAddr <= 4'(LASTA)) ? regs[regAddr] : 8'h00;

  always @(posedge clk or negedge rstN)
    if (!rstN) begin
      for (int i = 0; i <= LASTA; i++) regs[i] <= 8'h30 + 8'(i);
    end else if (regWr && regAddr <= 4'(LASTA)) regs[regAddr] <= regWdata;

  // R10 monitor: output enable must not move while SCL is high
  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && sclM) r10Viol++;
    prevOe = sdaOe;
  end

  function automatic int stepPtr(input int p);
    return (p == LASTA) ? 0 : p + 1;
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(4); sclM = 1'b1; waitClk(4);
    sdaM = 1'b0; waitClk(4); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitClk(4); sdaM = 1'b0; waitClk(4); sclM = 1'b1; waitClk(4);
    sdaM = 1'b1; waitClk(8);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      waitClk(4); sdaM = b[i]; waitClk(4); sclM = 1'b1; waitClk(8); sclM = 1'b0;
    end
    waitClk(4); sdaM = 1'b1; waitClk(4); sclM = 1'b1; waitClk(4);
    acked = !sdaLine; waitClk(4); sclM = 1'b0;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit giveAck);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(8); sclM = 1'b1; waitClk(4); b[i] = sdaLine; waitClk(4); sclM = 1'b0;
    end
    waitClk(4); sdaM = giveAck ? 1'b0 : 1'b1; waitClk(4); sclM = 1'b1;
    waitClk(8); sclM = 1'b0; sdaM = 1'b1;
  endtask

  task automatic doWrite(input int addr, input int n, input logic [7:0] seed8, input bit busy);
    bit a; int p = addr;
    busStart();
    sendByte(ID_WR, a); chk(a, "R2 id ack", a, 1);
    sendByte(8'(addr), a); chk(a, "R3 addr ack", a, 1);
    regBusy = busy;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed8 + 8'(k * 37);
      sendByte(d, a);
      if (busy) chk(!a, "R7 busy nack", a, 0);
      else begin
        chk(a, "R3 data ack", a, 1);
        model[p] = d; p = stepPtr(p);
      end
    end
    regBusy = 1'b0;
    busStop();
  endtask

  task automatic doRead(input int addr, input int n, input string req);
    bit a; logic [7:0] d; int p = addr;
    busStart();
    sendByte(ID_WR, a); chk(a, "R5 id ack", a, 1);
    sendByte(8'(addr), a); chk(a, "R5 addr ack", a, 1);
    busStart();
    sendByte(ID_RD, a); chk(a, "R5 read id ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(d, k < n - 1);
      chk(d === model[p], req, d, model[p]);
      p = stepPtr(p);
    end
    busStop();
  endtask

  initial begin
    bit a; logic [7:0] d; logic [7:0] keep;
    void'($urandom(32'd20251));
    for (int i = 0; i <= LASTA; i++) model[i] = 8'h30 + 8'(i);
    waitClk(5); rstN = 1'b1; waitClk(3);
    // R1 reset state
    chk(sdaOe == 1'b0 && regWr == 1'b0, "R1 idle outputs", {sdaOe, regWr}, 0);
    chk(regAddr == 4'd0, "R1 pointer", regAddr, 0);
    // R8 START ignored before power-up completes
    busStart(); sendByte(ID_WR, a); chk(!a, "R8 no ack before init", a, 0);
    sendByte(8'h02, a); sendByte(8'hEE, a); busStop();
    chk(regs[2] === model[2], "R8 no write", regs[2], model[2]);
    initDone = 1'b1; waitClk(10);
    // R3 single write
    doWrite(2, 1, 8'hA5, 1'b0);
    chk(regs[2] === 8'hA5, "R3 stored", regs[2], 8'hA5);
    // R4 burst across the top
    doWrite(7, 3, 8'h5C, 1'b0);
    chk(regs[0] === model[0] && regs[8] === model[8], "R4 wrap write", regs[0], model[0]);
    // R5 read across the top
    doRead(7, 4, "R5 wrap read");
    // R2 mismatching identification
    keep = regs[4];
    busStart(); sendByte(ID_BAD, a); chk(!a, "R2 bad id nack", a, 0);
    sendByte(8'h04, a); chk(!a, "R2 ignored addr", a, 0);
    sendByte(8'h77, a); chk(!a, "R2 ignored data", a, 0);
    busStop();
    chk(regs[4] === keep, "R2 no write", regs[4], keep);
    // R6 master NACK ends the read
    busStart(); sendByte(ID_WR, a); sendByte(8'h05, a); busStart();
    sendByte(ID_RD, a); recvByte(d, 1'b0);
    chk(d === model[5], "R6 first byte", d, model[5]);
    recvByte(d, 1'b0);
    chk(d === 8'hFF, "R6 released after nack", d, 8'hFF);
    busStop();
    // R7 busy refuses write
    keep = regs[3];
    doWrite(3, 1, 8'h99, 1'b1);
    chk(regs[3] === keep, "R7 not stored", regs[3], keep);
    doRead(3, 1, "R7 readback");
    // R9 traffic after STOP without START
    keep = regs[1];
    sendByte(ID_WR, a); chk(!a, "R9 no ack after stop", a, 0);
    sendByte(8'h01, a); sendByte(8'h42, a); chk(!a, "R9 data ignored", a, 0);
    busStop();
    chk(regs[1] === keep, "R9 no write", regs[1], keep);
    // random mix
    for (int t = 0; t < 24; t++) begin
      int addr = int'($urandom_range(0, LASTA));
      int n = int'($urandom_range(1, 4));
      if ($urandom_range(0, 1) == 0) doWrite(addr, n, 8'($urandom), 1'b0);
      else doRead(addr, n, "R5 random read");
    end
    for (int i = 0; i <= LASTA; i++)
      chk(regs[i] === model[i], "R4 final contents", regs[i], model[i]);
    chk(r10Viol == 0, "R10 oe change with SCL high", r10Viol, 0);
    finishRun();
  end
endmodule